// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a compact integer processor that completes one instruction per clock. Each cycle it presents a word index to an instruction memory, decodes the returned 32-bit word, reads two operands from a 32-entry register file, and then does one of four things: writes an arithmetic or compare result back, moves a word between a register and the data memory, or redirects the program counter. The instruction set is a small subset of a classic 32-bit RISC encoding: add, subtract, set-if-less-than, jump-to-register, load word, store word, branch-if-equal, branch-if-not-equal and absolute jump.

Both memories sit outside the block and answer combinationally. The fetch port carries a word index. The data port carries a byte address, write data, a write strobe and read data. Writes are taken on the rising clock edge. A system preloads a program and some data, releases reset and lets the core run. The results become visible through the stores the program performs.

Top module: `mini_risc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and registers 1 to 31 become 0, so that `imem_addr` reads 0 after that edge.
- R2: For an opcode of 0, the instruction fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. Funct 0x20 writes rs+rt to rd and funct 0x22 writes rs−rt to rd, both modulo 2^32.
- R3: Funct 0x2A writes 1 to rd when rs is less than rt as signed 32-bit values, and writes 0 otherwise.
- R4: Register 0 reads as zero in every operand position, and any write aimed at it is dropped.
- R5: Opcode 0x23 (load word) places on `dmem_addr` the value of rs plus the sign-extended immediate in bits [15:0], and writes `dmem_rdata` into rt. The word 0x8E680020 loads from register 19 plus 32 into register 8.
- R6: Opcode 0x2B (store word) drives the same address, puts rt on `dmem_wdata` and raises `dmem_we`. No other instruction raises `dmem_we`. The word 0xAD2804B0 stores register 8 to register 9 plus 1200.
- R7: Opcode 4 (branch if rs equals rt) and opcode 5 (branch if rs differs from rt) set the next PC to PC+4 plus the sign-extended immediate times 4 when taken, and to PC+4 when not taken. Backward offsets work.
- R8: Opcode 2 sets the next PC to PC[31:28] followed by instruction bits [25:0] and two zero bits.
- R9: Opcode 0 with funct 0x08 sets the next PC to the value of rs and writes no register.
- R10: Any other opcode, and opcode 0 with any other funct, writes no register, performs no store and advances the PC by 4.
- R11: `imem_addr` equals PC bits [IAW+1:2]. Sequential instructions therefore advance it by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | IAW | Word index of the instruction being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address of the load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken at the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
The assertions assume that both memories answer within the same cycle, so that `imem_data` always belongs to the current `imem_addr`. They also assume that IAW is at most 16, so that a branch offset wraps correctly in the index space. The bench models both memories as combinational arrays and keeps every fetch, target and data address inside them. Its program avoids self-modifying code and keeps every loop bounded once reset has cleared the registers.

// File: rtl/mini_risc_core.sv
module mini_risc_core #(
  parameter int IAW = 10
) (
  input  logic           clk,
  input  logic           rst,
  output logic [IAW-1:0] imem_addr,
  input  logic [31:0]    imem_data,
  output logic [31:0]    dmem_addr,
  output logic [31:0]    dmem_wdata,
  output logic           dmem_we,
  input  logic [31:0]    dmem_rdata
);
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] FN_JR    = 6'h08;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;
  localparam logic [5:0] FN_SLT   = 6'h2A;

  logic [31:0] pc, pc_next, pc_seq;
  logic [31:0] regs [0:31];
  logic [31:0] rs_val, rt_val, wr_data, imm_sx;
  logic [4:0]  wr_idx;
  logic        wr_en;

  wire [5:0] op    = imem_data[31:26];
  wire [4:0] rs    = imem_data[25:21];
  wire [4:0] rt    = imem_data[20:16];
  wire [4:0] rd    = imem_data[15:11];
  wire [5:0] funct = imem_data[5:0];

  assign imm_sx = {{16{imem_data[15]}}, imem_data[15:0]};
  assign rs_val = (rs == 5'd0) ? 32'd0 : regs[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : regs[rt];
  assign pc_seq = pc + 32'd4;

  assign imem_addr  = pc[IAW+1:2];
  assign dmem_addr  = rs_val + imm_sx;
  assign dmem_wdata = rt_val;
  assign dmem_we    = (op == OP_STORE);

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = rd;
    wr_data = 32'd0;
    pc_next = pc_seq;
    case (op)
      OP_RTYPE: case (funct)
        FN_ADD: begin wr_en = 1'b1; wr_data = rs_val + rt_val; end
        FN_SUB: begin wr_en = 1'b1; wr_data = rs_val - rt_val; end
        FN_SLT: begin wr_en = 1'b1; wr_data = {31'd0, $signed(rs_val) < $signed(rt_val)}; end
        FN_JR:  pc_next = rs_val;
        default: ;
      endcase
      OP_LOAD: begin wr_en = 1'b1; wr_idx = rt; wr_data = dmem_rdata; end
      OP_BEQ:  if (rs_val == rt_val) pc_next = pc_seq + {imm_sx[29:0], 2'b00};
      OP_BNE:  if (rs_val != rt_val) pc_next = pc_seq + {imm_sx[29:0], 2'b00};
      OP_JUMP: pc_next = {pc[31:28], imem_data[25:0], 2'b00};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) regs[i] <= 32'd0;
    end else begin
      pc <= pc_next;
      if (wr_en && wr_idx != 5'd0) regs[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/mini_risc_core_chk.sv
module mini_risc_core_chk #(
  parameter int IAW = 10
) (
  input logic           clk,
  input logic           rst,
  input logic [IAW-1:0] imem_addr,
  input logic [31:0]    imem_data,
  input logic           dmem_we,
  input logic [31:0]    rs_val,
  input logic [31:0]    rt_val
);
  wire [5:0] op  = imem_data[31:26];
  wire [5:0] fn  = imem_data[5:0];
  wire       known = (op == 6'h00 && (fn == 6'h20 || fn == 6'h22 || fn == 6'h2A || fn == 6'h08)) ||
                     op == 6'h02 || op == 6'h04 || op == 6'h05 || op == 6'h23 || op == 6'h2B;
  logic rst_q;

  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) if (rst_q) assert_reset_pc_R1: assert (imem_addr == '0);

  assert_zero_reg_R4: assert property (@(posedge clk) disable iff (rst)
    (imem_data[25:21] == 5'd0) |-> (rs_val == 32'd0));

  assert_store_only_R6: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (op == 6'h2B));

  assert_beq_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val == rt_val) |=>
      (imem_addr == $past(imem_addr) + IAW'(1) + $past(imem_data[IAW-1:0])));

  assert_bne_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h05 && rs_val == rt_val) |=> (imem_addr == $past(imem_addr) + IAW'(1)));

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h02) |=> (imem_addr == $past(imem_data[IAW-1:0])));

  assert_jr_target_R9: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h00 && fn == 6'h08) |=> (imem_addr == $past(rs_val[IAW+1:2])));

  assert_unknown_nop_R10: assert property (@(posedge clk) disable iff (rst)
    !known |=> (imem_addr == $past(imem_addr) + IAW'(1)));
endmodule

bind mini_risc_core mini_risc_core_chk #(.IAW(IAW)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_we(dmem_we), .rs_val(rs_val), .rt_val(rt_val)
);

// File: tb/test_mini_risc_core.sv
module test_mini_risc_core;
  localparam int CLK_PERIOD = 10;
  localparam int IAW = 6;
  localparam int DAW = 9;
  localparam int NPROG = 42;
  localparam int NEXP = 14;
  localparam logic [31:0] FILL = 32'hDEADBEEF;

  function automatic logic [31:0] ri(input int op, input int rs, input int rt, input int imm);
    logic [31:0] o = op, s = rs, t = rt, m = imm;
    return {o[5:0], s[4:0], t[4:0], m[15:0]};
  endfunction
  function automatic logic [31:0] rr(input int rs, input int rt, input int rd, input int fn);
    logic [31:0] s = rs, t = rt, d = rd, f = fn;
    return {6'd0, s[4:0], t[4:0], d[4:0], 5'd0, f[5:0]};
  endfunction
  function automatic logic [31:0] jj(input int idx);
    logic [31:0] x = idx;
    return {6'd2, x[25:0]};
  endfunction

  localparam logic [31:0] PROG [0:NPROG-1] = '{
    ri(35,0,1,0), ri(35,0,2,4), ri(35,0,3,8),
    rr(1,2,4,32), rr(1,2,5,34), rr(3,1,6,42), rr(1,3,7,42),
    rr(1,2,0,32),
    ri(4,1,2,5), ri(5,1,2,1), rr(1,1,17,32),
    jj(13), rr(1,1,9,32),
    ri(35,0,10,12), rr(10,0,0,8), rr(1,1,11,32), rr(2,2,11,32),
    32'hFFFFFFFF, rr(1,1,31,63),
    ri(35,0,13,20), ri(4,0,0,1), rr(1,1,14,32),
    rr(12,1,12,32), ri(5,12,13,-2),
    ri(35,0,15,16), 32'h8E680020, 32'hAD2804B0,
    ri(43,15,4,0), ri(43,15,5,4), ri(43,15,6,8), ri(43,15,7,12),
    ri(43,15,0,16), ri(43,15,17,20), ri(43,15,11,24), ri(43,15,31,28),
    ri(43,15,12,32), ri(43,15,14,36), ri(43,15,10,40), ri(43,15,1,-4),
    ri(35,15,16,0), ri(43,15,16,44), jj(41)
  };

  // word, expected value, requirement
  localparam int EXP_W [0:NEXP-1] = '{300, 32, 33, 34, 35, 36, 37, 38, 39, 40, 41, 42, 31, 43};
  localparam logic [31:0] EXP_V [0:NEXP-1] = '{32'hCAFE0001, 32'd12, 32'hFFFFFFFE, 32'd1, 32'd0,
    32'd0, 32'd0, 32'd0, 32'd0, 32'd15, 32'd0, 32'h44, 32'd5, 32'd12};
  // R6 literal store / R8 skipped add, R2 add, R2 sub, R3 slt true, R3 slt false,
  // R4 zero reg, R7 bne skip, R9 jr skip, R10 nop no write, R7 loop, R7 beq skip,
  // R5 load, R6 negative displacement, R5 load with nonzero base
  localparam int EXP_R [0:NEXP-1] = '{6, 2, 2, 3, 3, 4, 7, 9, 10, 7, 7, 5, 6, 5};

  logic clk = 1'b0, rst = 1'b1;
  logic [IAW-1:0] imem_addr;
  logic [31:0] imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we;
  logic [31:0] imem [0:(1<<IAW)-1];
  logic [31:0] dmem [0:(1<<DAW)-1];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr[DAW+1:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[DAW+1:2]] <= dmem_wdata;

  mini_risc_core #(.IAW(IAW)) i_mini_risc_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_data();
    for (int i = 0; i < (1<<DAW); i++) dmem[i] = FILL;
    dmem[0] = 32'd5; dmem[1] = 32'd7; dmem[2] = 32'hFFFFFFFD;
    dmem[3] = 32'h44; dmem[4] = 32'd128; dmem[5] = 32'd15; dmem[8] = 32'hCAFE0001;
  endtask

  initial begin
    for (int i = 0; i < (1<<IAW); i++) imem[i] = (i < NPROG) ? PROG[i] : 32'd0;
    load_data();
    repeat (3) @(negedge clk);
    check("R1 reset index", 32'(imem_addr), 32'd0);
    check("R6 no store in reset", 32'(dmem_we), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 sequential index", 32'(imem_addr), 32'd1);
    repeat (150) @(negedge clk);
    check("R8 halt self-jump", 32'(imem_addr), 32'd41);
    for (int k = 0; k < NEXP; k++)
      check($sformatf("R%0d word %0d", EXP_R[k], EXP_W[k]), dmem[EXP_W[k]], EXP_V[k]);
    check("R8 skipped add left store address", dmem[302], FILL);
    // R1: reset mid-run clears registers; the loop only terminates if r12 starts at 0
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", 32'(imem_addr), 32'd0);
    load_data();
    rst = 1'b0;
    repeat (150) @(negedge clk);
    check("R1 registers cleared", dmem[40], 32'd15);
    check("R2 rerun add", dmem[32], 32'd12);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule